// File: doc/BRIEF.md
# Reset Pin Glitch Qualifier

This block sits between an external, active-low reset pin and the chip's reset controller. It brings the asynchronous pin into the clock domain through a short flop chain, then counts how many consecutive clocks the pin stays asserted. When an assertion has lasted long enough, the block sends the reset controller a single-cycle request to start a reset. An assertion that ends early is sorted by its length. A very short blip is treated as noise and ignored. A pulse of intermediate length sets a sticky glitch flag.

Software reads the glitch flag and clears it by writing a 1 to it. A power-on reset also clears the flag, and so does a qualified reset assertion. The reset sequencing that follows the request is outside this block, and so are any other status fields.

Top module: `reset_glitch_qualifier`

## Requirements
- R1: The pin passes through SYNC_STAGES (default 2) flops before counting. With the pin driven low just after a clock edge and held low, the request output is first high SYNC_STAGES+VALID_MIN edges later (12 with defaults).
- R2: An assertion that reaches VALID_MIN (default 10) consecutive synchronized clocks raises `valid_rst_req` for exactly one cycle. It is raised once per assertion however long the pin is held, because the counter saturates and does not wrap.
- R3: An assertion of NOISE_MAX (default 2) clocks or fewer leaves `glitch_flag` unchanged and raises no request.
- R4: An assertion longer than NOISE_MAX but shorter than VALID_MIN clocks sets `glitch_flag` and raises no request. Its length is judged when the pin deasserts, and the flag is visible SYNC_STAGES+1 edges after release.
- R5: A qualified reset assertion clears `glitch_flag`, in the same cycle in which the request is raised.
- R6: Synchronous active-high `rst` (power-on) clears `glitch_flag` and holds `valid_rst_req` low.
- R7: A cycle with `sw_wr_en`=1 and `sw_wr_data`=1 clears `glitch_flag`. A write of 0, or `sw_wr_data`=1 with `sw_wr_en`=0, leaves it unchanged.
- R8: When a glitch set and a software clear fall in the same cycle, the flag ends set.
- R9: The count restarts on every fresh assertion. Two 6-clock assertions separated by one deasserted clock produce no request, and they set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| sw_wr_en | input | 1 | Software write strobe for the flag bit |
| sw_wr_data | input | 1 | Software write data; 1 clears the flag |
| valid_rst_req | output | 1 | One-cycle request to the reset controller |
| glitch_flag | output | 1 | Sticky glitch indication |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a noise limit of 2 and a qualification length of 10. These values put every class boundary (2/3 and 9/10) within reach of short directed pulses. They also make the exact request latency of 12 cycles a fixed number the bench can check. A 300-cycle hold drives the 4-bit counter far past its saturation point, which exposes any wrap that would raise a second request.

// File: rtl/rgq_pkg.sv
package rgq_pkg;

    // Default qualification constants
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_NOISE_MAX   = 2;
    localparam int unsigned DEF_VALID_MIN   = 10;

    // Length classes of a finished pin assertion
    typedef enum logic [1:0] {
        PCLS_NONE   = 2'd0,
        PCLS_NOISE  = 2'd1,
        PCLS_GLITCH = 2'd2,
        PCLS_VALID  = 2'd3
    } pulse_class_e;

    // Event emitted when an assertion ends
    typedef struct packed {
        logic         fire;
        pulse_class_e cls;
    } pulse_end_t;

    // Sort an assertion length into its class
    function automatic pulse_class_e classify(input int unsigned len,
                                              input int unsigned noise_max,
                                              input int unsigned valid_min);
        if (len == 0)
            return PCLS_NONE;
        else if (len <= noise_max)
            return PCLS_NOISE;
        else if (len < valid_min)
            return PCLS_GLITCH;
        else
            return PCLS_VALID;
    endfunction

endpackage

// File: rtl/rgq_sync.sv
module rgq_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RESET_VAL;
                    else     chain_q[g] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= RESET_VAL;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rgq_pulse_timer.sv
module rgq_pulse_timer
    import rgq_pkg::*;
#(
    parameter int unsigned NOISE_MAX = DEF_NOISE_MAX,
    parameter int unsigned VALID_MIN = DEF_VALID_MIN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       asserted_i,
    output logic       valid_hit_o,
    output logic       valid_pulse_o,
    output pulse_end_t end_o
);
    localparam int unsigned CNT_W = $clog2(VALID_MIN + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(VALID_MIN);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             valid_q;
    logic             at_sat;

    assign at_sat  = (cnt_q == CNT_SAT);
    assign cnt_inc = at_sat ? cnt_q : cnt_q + 1'b1;

    // Qualification point: the asserted clock that brings the count to VALID_MIN
    assign valid_hit_o = asserted_i && (cnt_q == CNT_SAT - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= valid_hit_o;
            if (asserted_i) cnt_q <= cnt_inc;
            else            cnt_q <= '0;
        end
    end

    // Judge the length when the assertion ends
    always_comb begin
        end_o.fire = 1'b0;
        end_o.cls  = PCLS_NONE;
        if (!asserted_i && cnt_q != '0) begin
            end_o.fire = 1'b1;
            end_o.cls  = classify(int'(cnt_q), NOISE_MAX, VALID_MIN);
        end
    end

    assign valid_pulse_o = valid_q;

    // R2: request lasts one cycle only
    p_single_req_r2: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    // R2: counter never runs past its saturation value
    p_cnt_sat_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_SAT);
    // R9: a deasserted clock restarts the count
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
        !asserted_i |=> cnt_q == '0);
endmodule

// File: rtl/rgq_glitch_flag.sv
module rgq_glitch_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic valid_clr_i,
    input  logic sw_clr_i,
    output logic flag_o
);
    logic flag_q;

    // Set dominates every clear source
    always_ff @(posedge clk) begin
        if (rst)                         flag_q <= 1'b0;
        else if (set_i)                  flag_q <= 1'b1;
        else if (valid_clr_i || sw_clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R4 / R8: a set always lands
    p_set_lands_r8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    // R7: software clear takes effect when no set competes
    p_sw_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sw_clr_i && !set_i) |=> !flag_o);
    // R5: qualified reset clears
    p_valid_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_clr_i && !set_i) |=> !flag_o);
    // R3 / R7: no event, no change
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !valid_clr_i && !sw_clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/reset_glitch_qualifier.sv
module reset_glitch_qualifier
    import rgq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    parameter int unsigned NOISE_MAX   = DEF_NOISE_MAX,
    parameter int unsigned VALID_MIN   = DEF_VALID_MIN
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    input  logic sw_wr_en,
    input  logic sw_wr_data,
    output logic valid_rst_req,
    output logic glitch_flag
);
    logic       pin_sync;
    logic       pin_asserted;
    logic       valid_hit;
    logic       glitch_set;
    logic       sw_clr;
    pulse_end_t pulse_end;

    rgq_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (ext_rst_n),
        .q_o (pin_sync)
    );

    assign pin_asserted = !pin_sync;

    rgq_pulse_timer #(
        .NOISE_MAX (NOISE_MAX),
        .VALID_MIN (VALID_MIN)
    ) u_timer (
        .clk           (clk),
        .rst           (rst),
        .asserted_i    (pin_asserted),
        .valid_hit_o   (valid_hit),
        .valid_pulse_o (valid_rst_req),
        .end_o         (pulse_end)
    );

    assign glitch_set = pulse_end.fire && (pulse_end.cls == PCLS_GLITCH);
    assign sw_clr     = sw_wr_en && sw_wr_data;

    rgq_glitch_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .set_i       (glitch_set),
        .valid_clr_i (valid_hit),
        .sw_clr_i    (sw_clr),
        .flag_o      (glitch_flag)
    );

    // R6: power-on reset leaves both outputs low
    p_por_clear_r6: assert property (@(posedge clk)
        rst |=> (!glitch_flag && !valid_rst_req));
    // R4: a request never comes together with a glitch verdict
    p_no_mix_r4: assert property (@(posedge clk) disable iff (rst)
        !(valid_hit && glitch_set));
endmodule

// File: tb/reset_glitch_qualifier_tb.sv
module reset_glitch_qualifier_tb;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst;
    logic ext_rst_n;
    logic sw_wr_en;
    logic sw_wr_data;
    logic valid_rst_req;
    logic glitch_flag;

    int checks   = 0;
    int failures = 0;
    int req_seen = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_glitch_qualifier u_dut (
        .clk           (clk),
        .rst           (rst),
        .ext_rst_n     (ext_rst_n),
        .sw_wr_en      (sw_wr_en),
        .sw_wr_data    (sw_wr_data),
        .valid_rst_req (valid_rst_req),
        .glitch_flag   (glitch_flag)
    );

    // Count request cycles, sampled away from the active edge
    always @(negedge clk) if (valid_rst_req) req_seen++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Hold the pin low for len cycles, then release and let it settle
    task automatic pulse(input int len);
        ext_rst_n = 1'b0;
        idle(len);
        ext_rst_n = 1'b1;
        idle(6);
    endtask

    task automatic sw_write(input bit en, input bit d);
        sw_wr_en = en; sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0; sw_wr_data = 1'b0;
    endtask

    task automatic clear_flag();
        sw_write(1'b1, 1'b1);
    endtask

    task automatic t_reset();
        check(glitch_flag == 1'b0, "R6 flag after reset", glitch_flag, 0);
        check(valid_rst_req == 1'b0, "R6 request after reset", valid_rst_req, 0);
    endtask

    task automatic t_noise();
        req_seen = 0;
        pulse(1);
        check(glitch_flag == 1'b0, "R3 len1 flag clear", glitch_flag, 0);
        pulse(2);
        check(glitch_flag == 1'b0, "R3 len2 flag clear", glitch_flag, 0);
        pulse(4);
        pulse(2);
        check(glitch_flag == 1'b1, "R3 len2 keeps set flag", glitch_flag, 1);
        check(req_seen == 0, "R3 no request", req_seen, 0);
        clear_flag();
    endtask

    task automatic t_glitch_bounds();
        req_seen = 0;
        pulse(3);
        check(glitch_flag == 1'b1, "R4 len3 sets flag", glitch_flag, 1);
        clear_flag();
        pulse(9);
        check(glitch_flag == 1'b1, "R4 len9 sets flag", glitch_flag, 1);
        check(req_seen == 0, "R4 no request", req_seen, 0);
        clear_flag();
        // timing of the set: SYNC_STAGES+1 edges after release
        ext_rst_n = 1'b0;
        idle(5);
        ext_rst_n = 1'b1;
        idle(2);
        check(glitch_flag == 1'b0, "R4 flag not yet set", glitch_flag, 0);
        idle(1);
        check(glitch_flag == 1'b1, "R4 flag set at 3rd edge", glitch_flag, 1);
        clear_flag();
    endtask

    task automatic t_latency();
        int lat = 0;
        ext_rst_n = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            @(negedge clk);
            if (valid_rst_req && lat == 0) lat = i;
        end
        ext_rst_n = 1'b1;
        idle(6);
        check(lat == 12, "R1 request latency", lat, 12);
    endtask

    task automatic t_valid();
        req_seen = 0;
        pulse(10);
        check(req_seen == 1, "R2 len10 one request", req_seen, 1);
        check(glitch_flag == 1'b0, "R2 len10 no flag", glitch_flag, 0);
        req_seen = 0;
        pulse(300);
        check(req_seen == 1, "R2 long hold one request", req_seen, 1);
        check(glitch_flag == 1'b0, "R2 long hold no flag", glitch_flag, 0);
    endtask

    task automatic t_valid_clears();
        pulse(5);
        check(glitch_flag == 1'b1, "R5 setup flag", glitch_flag, 1);
        ext_rst_n = 1'b0;
        idle(11);
        check(glitch_flag == 1'b1, "R5 flag before qualify", glitch_flag, 1);
        idle(1);
        check(glitch_flag == 1'b0, "R5 flag cleared with request", glitch_flag, 0);
        check(valid_rst_req == 1'b1, "R5 request same cycle", valid_rst_req, 1);
        ext_rst_n = 1'b1;
        idle(6);
    endtask

    task automatic t_sw();
        pulse(4);
        sw_write(1'b1, 1'b0);
        check(glitch_flag == 1'b1, "R7 write0 no effect", glitch_flag, 1);
        sw_write(1'b0, 1'b1);
        check(glitch_flag == 1'b1, "R7 no strobe no effect", glitch_flag, 1);
        sw_write(1'b1, 1'b1);
        check(glitch_flag == 1'b0, "R7 write1 clears", glitch_flag, 0);
    endtask

    task automatic t_set_wins();
        ext_rst_n = 1'b0;
        idle(5);
        ext_rst_n = 1'b1;
        idle(2);
        sw_write(1'b1, 1'b1);
        check(glitch_flag == 1'b1, "R8 set beats clear", glitch_flag, 1);
        idle(3);
        clear_flag();
    endtask

    task automatic t_restart();
        req_seen = 0;
        ext_rst_n = 1'b0; idle(6);
        ext_rst_n = 1'b1; idle(1);
        ext_rst_n = 1'b0; idle(6);
        ext_rst_n = 1'b1; idle(6);
        check(req_seen == 0, "R9 split pulse no request", req_seen, 0);
        check(glitch_flag == 1'b1, "R9 split pulse flags", glitch_flag, 1);
    endtask

    task automatic t_por();
        rst = 1'b1;
        idle(2);
        check(glitch_flag == 1'b0, "R6 power-on clears flag", glitch_flag, 0);
        rst = 1'b0;
        idle(4);
        check(glitch_flag == 1'b0, "R6 flag stays clear", glitch_flag, 0);
    endtask

    initial begin
        rst = 1'b1; ext_rst_n = 1'b1; sw_wr_en = 1'b0; sw_wr_data = 1'b0;
        idle(4);
        rst = 1'b0;
        idle(4);
        t_reset();
        t_noise();
        t_glitch_bounds();
        t_latency();
        t_valid();
        t_valid_clears();
        t_sw();
        t_set_wins();
        t_restart();
        t_por();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule